// File: doc/BRIEF.md
# Parallel Panel Command Bus Engine

This block moves single words between a host register port and an external display controller that hangs off a parallel system bus. The host places a command word in a command register, or a read-setup word in the read-data register, and then writes a start register. The engine then runs one bus cycle in three equal phases: select, strobe and release. It drives one of two chip selects, a register-select line that tells the controller whether the word is an index or data, and active-low write and read strobes.

On a write cycle the low 16 bits of the command word appear on the outgoing data lanes. On a read cycle the lanes are released and the value on the incoming lanes is captured as the strobe ends. The host polls a busy flag in a status register and fetches captured read data from the low half of the read-data register. Each phase length is a parameter. A start request that arrives while a cycle is in flight is dropped. A start request that lacks its start flag is dropped as well.

Top module: `panel_cmd_bus`

## Requirements
- R1: After reset both chip selects, both strobes and register select are high, output enable is low, the status register reads 0 and the read-data register reads 0.
- R2: Writing the write-start register (address 2) with bit 0 set, while the command register (address 0) has bit 28 set, runs a write cycle. The chosen chip select is low for 3*PHASE_CLKS cycles, starting the cycle after the register write. The write strobe is low for exactly the middle PHASE_CLKS of those cycles. The read strobe stays high.
- R3: During a cycle, register select equals bit 24 of the captured word: low for an index, high for data. During a write cycle the output enable is high and the data lanes carry bits 15:0 of the command word. Outside a write cycle the lanes read 0.
- R4: Bit 1 of the start word picks the sub panel chip select (1) or the main one (0). The other chip select stays high.
- R5: Status register (address 4) bit 1 reads 1 in exactly the cycles a transfer occupies and 0 otherwise. All other status bits read 0.
- R6: Writing the read-start register (address 3) with bit 0 set runs a read cycle with the same timing, using the read strobe and with output enable low. Register select follows bit 24 of the word last written to the read-data register (address 1). The incoming lanes are captured in the last strobe-low cycle. Reading address 1 returns that value in bits 15:0, with bits 31:16 zero.
- R7: A write-start or read-start request made while busy, including in the final busy cycle, is ignored.
- R8: A start word with bit 0 clear is ignored. A write-start request whose command word has bit 28 clear is ignored.
- R9: Rewriting the command or read-setup register during a cycle leaves that cycle's lanes and register select unchanged. The new value applies to the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host register write enable |
| reg_waddr | input | 3 | Host write address |
| reg_wdata | input | 32 | Host write data |
| reg_raddr | input | 3 | Host read address |
| reg_rdata | output | 32 | Host read data (combinational on reg_raddr) |
| cs_main_n | output | 1 | Main panel chip select, active low |
| cs_sub_n | output | 1 | Sub panel chip select, active low |
| rs | output | 1 | Register select: 0 index, 1 data |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| pbus_out | output | 16 | Outgoing panel data lanes |
| pbus_oe | output | 1 | Output enable for the data lanes |
| pbus_in | input | 16 | Incoming panel data lanes |

## Verification
A host register write and the engine's own end-of-cycle can land on the same clock edge. The bench provokes this by issuing a fresh start request in the final busy cycle of a transfer. It judges the result by requiring the bus to go idle on the next cycle and stay idle, with status bit 1 falling exactly when the cycle count says. A second collision writes the command or read-setup register while the strobe is low. The bench checks that the lanes and register select hold their captured values, and that the following cycle carries the new word.

// File: rtl/panel_cmd_pkg.sv
package panel_cmd_pkg;
    localparam logic [2:0] ADDR_CMD    = 3'd0;
    localparam logic [2:0] ADDR_RDDAT  = 3'd1;
    localparam logic [2:0] ADDR_WSTART = 3'd2;
    localparam logic [2:0] ADDR_RSTART = 3'd3;
    localparam logic [2:0] ADDR_STATUS = 3'd4;

    localparam int BIT_WRITE_FLAG = 28;
    localparam int BIT_DATA_FLAG  = 24;
    localparam int BIT_GO         = 0;
    localparam int BIT_SUB        = 1;
    localparam int BIT_BUSY       = 1;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SELECT,
        PH_STROBE,
        PH_RELEASE
    } phase_t;

    typedef struct packed {
        logic        wr_flag;
        logic        wr_rs;
        logic [15:0] wr_word;
        logic        rd_rs;
    } host_regs_t;
endpackage

// File: rtl/panel_cmd_regs.sv
module panel_cmd_regs
    import panel_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [2:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    input  logic        busy,
    input  logic [15:0] captured,
    output host_regs_t  regs,
    output logic        go_write,
    output logic        go_read,
    output logic        go_sub
);
    host_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (reg_we && reg_waddr == ADDR_CMD) begin
            regs_d.wr_flag = reg_wdata[BIT_WRITE_FLAG];
            regs_d.wr_rs   = reg_wdata[BIT_DATA_FLAG];
            regs_d.wr_word = reg_wdata[15:0];
        end
        if (reg_we && reg_waddr == ADDR_RDDAT) begin
            regs_d.rd_rs = reg_wdata[BIT_DATA_FLAG];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs     = regs_q;
    assign go_write = reg_we && reg_waddr == ADDR_WSTART && reg_wdata[BIT_GO] && regs_q.wr_flag;
    assign go_read  = reg_we && reg_waddr == ADDR_RSTART && reg_wdata[BIT_GO];
    assign go_sub   = reg_wdata[BIT_SUB];

    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            ADDR_STATUS: reg_rdata[BIT_BUSY] = busy;
            ADDR_RDDAT:  reg_rdata[15:0]     = captured;
            default:     reg_rdata           = '0;
        endcase
    end
endmodule

// File: rtl/panel_cmd_seq.sv
module panel_cmd_seq
    import panel_cmd_pkg::*;
#(
    parameter int PHASE_CLKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_write,
    input  logic        go_read,
    input  logic        go_sub,
    input  host_regs_t  regs,
    input  logic [15:0] pbus_in,
    output logic        busy,
    output logic [15:0] captured,
    output logic        cs_main_n,
    output logic        cs_sub_n,
    output logic        rs,
    output logic        wr_n,
    output logic        rd_n,
    output logic [15:0] pbus_out,
    output logic        pbus_oe
);
    localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(PHASE_CLKS - 1);

    typedef struct packed {
        phase_t        phase;
        logic [CW-1:0] cnt;
        logic          is_read;
        logic          sub;
        logic          rs;
        logic [15:0]   word;
        logic [15:0]   captured;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            PH_IDLE: begin
                if (go_write) begin
                    s_d.phase   = PH_SELECT;
                    s_d.cnt     = CNT_LOAD;
                    s_d.is_read = 1'b0;
                    s_d.sub     = go_sub;
                    s_d.rs      = regs.wr_rs;
                    s_d.word    = regs.wr_word;
                end else if (go_read) begin
                    s_d.phase   = PH_SELECT;
                    s_d.cnt     = CNT_LOAD;
                    s_d.is_read = 1'b1;
                    s_d.sub     = go_sub;
                    s_d.rs      = regs.rd_rs;
                    s_d.word    = '0;
                end
            end
            PH_SELECT: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_STROBE;
                    s_d.cnt   = CNT_LOAD;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_RELEASE;
                    s_d.cnt   = CNT_LOAD;
                    if (s_q.is_read) s_d.captured = pbus_in;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_RELEASE: begin
                if (s_q.cnt == '0) s_d.phase = PH_IDLE;
                else               s_d.cnt   = s_q.cnt - 1'b1;
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = s_q.phase != PH_IDLE;
    assign captured  = s_q.captured;
    assign cs_main_n = !(busy && !s_q.sub);
    assign cs_sub_n  = !(busy && s_q.sub);
    assign rs        = busy ? s_q.rs : 1'b1;
    assign wr_n      = !(s_q.phase == PH_STROBE && !s_q.is_read);
    assign rd_n      = !(s_q.phase == PH_STROBE && s_q.is_read);
    assign pbus_oe   = busy && !s_q.is_read;
    assign pbus_out  = pbus_oe ? s_q.word : 16'h0000;
endmodule

// File: rtl/panel_cmd_bus.sv
module panel_cmd_bus
    import panel_cmd_pkg::*;
#(
    parameter int PHASE_CLKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [2:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    output logic        cs_main_n,
    output logic        cs_sub_n,
    output logic        rs,
    output logic        wr_n,
    output logic        rd_n,
    output logic [15:0] pbus_out,
    output logic        pbus_oe,
    input  logic [15:0] pbus_in
);
    host_regs_t  regs_w;
    logic        busy_w;
    logic        go_write_w;
    logic        go_read_w;
    logic        go_sub_w;
    logic [15:0] captured_w;

    panel_cmd_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .busy      (busy_w),
        .captured  (captured_w),
        .regs      (regs_w),
        .go_write  (go_write_w),
        .go_read   (go_read_w),
        .go_sub    (go_sub_w)
    );

    panel_cmd_seq #(.PHASE_CLKS(PHASE_CLKS)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_write  (go_write_w),
        .go_read   (go_read_w),
        .go_sub    (go_sub_w),
        .regs      (regs_w),
        .pbus_in   (pbus_in),
        .busy      (busy_w),
        .captured  (captured_w),
        .cs_main_n (cs_main_n),
        .cs_sub_n  (cs_sub_n),
        .rs        (rs),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .pbus_out  (pbus_out),
        .pbus_oe   (pbus_oe)
    );
endmodule

// File: rtl/panel_cmd_bus_chk.sv
module panel_cmd_bus_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_main_n,
    input logic        cs_sub_n,
    input logic        rs,
    input logic        wr_n,
    input logic        rd_n,
    input logic [15:0] pbus_out,
    input logic        pbus_oe,
    input logic        busy
);
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && !rd_n));

    assert_rs_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cs_main_n) && !cs_main_n) |-> $stable(rs));

    assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs_main_n && !cs_sub_n));

    assert_strobe_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n || !rd_n) |-> busy);

    assert_read_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !pbus_oe);

    assert_lanes_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !$past(wr_n)) |-> $stable(pbus_out));
endmodule

bind panel_cmd_bus panel_cmd_bus_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_main_n (cs_main_n),
    .cs_sub_n  (cs_sub_n),
    .rs        (rs),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .pbus_out  (pbus_out),
    .pbus_oe   (pbus_oe),
    .busy      (busy_w)
);

// File: tb/panel_cmd_bus_tb_top.sv
module panel_cmd_bus_tb_top;
    localparam int P = 3;
    localparam int SPAN = 3 * P;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        cs_main_n, cs_sub_n, rs, wr_n, rd_n, pbus_oe;
    logic [15:0] pbus_out;
    logic [15:0] pbus_in = '0;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    panel_cmd_bus #(.PHASE_CLKS(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .cs_main_n(cs_main_n), .cs_sub_n(cs_sub_n), .rs(rs), .wr_n(wr_n),
        .rd_n(rd_n), .pbus_out(pbus_out), .pbus_oe(pbus_oe), .pbus_in(pbus_in)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pack_now();
        return {8'h0, reg_rdata, cs_main_n, cs_sub_n, wr_n, rd_n, rs, pbus_oe, 1'b0, 1'b0, pbus_out};
    endfunction

    function automatic logic [63:0] pack_exp(input bit act, input bit is_rd, input bit sub,
                                             input bit rsv, input logic [15:0] dat, input int k);
        bit busy = act && k >= 1 && k <= SPAN;
        bit strobe = busy && k > P && k <= 2 * P;
        logic [31:0] st = busy ? 32'h2 : 32'h0;
        return {8'h0, st, !(busy && !sub), !(busy && sub), !(strobe && !is_rd),
                !(strobe && is_rd), busy ? rsv : 1'b1, busy && !is_rd, 1'b0, 1'b0,
                (busy && !is_rd) ? dat : 16'h0};
    endfunction

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // Issue a start write and watch SPAN+2 cycles; optional second register write at inj_k.
    task automatic xfer(input logic [2:0] sa, input logic [31:0] sd, input bit act,
                        input bit is_rd, input bit sub, input bit rsv, input logic [15:0] dat,
                        input int inj_k, input logic [2:0] inj_a, input logic [31:0] inj_d,
                        input string tag);
        reg_raddr = panel_cmd_pkg::ADDR_STATUS;
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = sa; reg_wdata = sd;
        for (int k = 1; k <= SPAN + 2; k++) begin
            @(negedge clk);
            if (k == 1 || k == inj_k + 1) reg_we = 1'b0;
            chk(tag, pack_now(), pack_exp(act, is_rd, sub, rsv, dat, k));
            if (k == inj_k) begin
                reg_we = 1'b1; reg_waddr = inj_a; reg_wdata = inj_d;
            end
        end
        reg_we = 1'b0;
    endtask

    task automatic check_rdata(input logic [15:0] exp, input string tag);
        reg_raddr = panel_cmd_pkg::ADDR_RDDAT;
        @(negedge clk);
        chk(tag, {32'h0, reg_rdata}, {48'h0, exp});
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] last_rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reg_raddr = panel_cmd_pkg::ADDR_STATUS;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset pins/status", pack_now(), pack_exp(1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 0));
        check_rdata(16'h0, "R1 read data after reset");

        // R2 R3 R4 R5 write sweep; R6 read sweep
        last_rd = 16'h0;
        for (int sub = 0; sub < 2; sub++) begin
            for (int rsv = 0; rsv < 2; rsv++) begin
                for (int i = 0; i < 4; i++) begin
                    logic [15:0] d = 16'(16'h1 << (i * 5)) ^ 16'(i * 16'h3c5a) ^ 16'(sub * 16'h8001 + rsv * 16'h0240);
                    reg_write(panel_cmd_pkg::ADDR_CMD, (32'h1 << 28) | (32'(rsv) << 24) | 32'(d));
                    xfer(panel_cmd_pkg::ADDR_WSTART, (32'(sub) << 1) | 32'h1, 1'b1, 1'b0, sub[0],
                         rsv[0], d, 0, 3'd0, 32'h0, "R2 R3 R4 R5 write cycle");
                    check_rdata(last_rd, "R6 read data untouched by write");
                    reg_write(panel_cmd_pkg::ADDR_RDDAT, 32'(rsv) << 24);
                    pbus_in = ~d;
                    xfer(panel_cmd_pkg::ADDR_RSTART, (32'(sub) << 1) | 32'h1, 1'b1, 1'b1, sub[0],
                         rsv[0], 16'h0, 0, 3'd0, 32'h0, "R4 R5 R6 read cycle");
                    pbus_in = 16'h5555;
                    last_rd = ~d;
                    check_rdata(last_rd, "R6 captured lanes");
                end
            end
        end

        // R8: start flag clear, and write flag clear in command
        reg_write(panel_cmd_pkg::ADDR_CMD, (32'h1 << 28) | 32'h1234);
        xfer(panel_cmd_pkg::ADDR_WSTART, 32'h2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 0, 3'd0, 32'h0,
             "R8 go bit clear on write start");
        xfer(panel_cmd_pkg::ADDR_RSTART, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 0, 3'd0, 32'h0,
             "R8 go bit clear on read start");
        reg_write(panel_cmd_pkg::ADDR_CMD, (32'h1 << 24) | 32'h4321);
        xfer(panel_cmd_pkg::ADDR_WSTART, 32'h1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 0, 3'd0, 32'h0,
             "R8 write flag clear in command");

        // R7: start while busy, mid-cycle and in the final busy cycle
        reg_write(panel_cmd_pkg::ADDR_CMD, (32'h1 << 28) | (32'h1 << 24) | 32'hbeef);
        xfer(panel_cmd_pkg::ADDR_WSTART, 32'h1, 1'b1, 1'b0, 1'b0, 1'b1, 16'hbeef,
             2, panel_cmd_pkg::ADDR_WSTART, 32'h3, "R7 write start while busy");
        xfer(panel_cmd_pkg::ADDR_WSTART, 32'h3, 1'b1, 1'b0, 1'b1, 1'b1, 16'hbeef,
             SPAN, panel_cmd_pkg::ADDR_RSTART, 32'h1, "R7 start in last busy cycle");
        xfer(panel_cmd_pkg::ADDR_WSTART, 32'h1, 1'b1, 1'b0, 1'b0, 1'b1, 16'hbeef,
             P + 1, panel_cmd_pkg::ADDR_RSTART, 32'h3, "R7 read start during write strobe");

        // R9: rewrite command during strobe; next cycle uses the new word
        xfer(panel_cmd_pkg::ADDR_WSTART, 32'h1, 1'b1, 1'b0, 1'b0, 1'b1, 16'hbeef,
             P + 1, panel_cmd_pkg::ADDR_CMD, (32'h1 << 28) | 32'h0f0f, "R9 command rewrite in flight");
        xfer(panel_cmd_pkg::ADDR_WSTART, 32'h3, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0f0f, 0, 3'd0, 32'h0,
             "R9 new command on next cycle");
        reg_write(panel_cmd_pkg::ADDR_RDDAT, 32'h1 << 24);
        pbus_in = 16'ha5c3;
        xfer(panel_cmd_pkg::ADDR_RSTART, 32'h1, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0,
             2, panel_cmd_pkg::ADDR_RDDAT, 32'h0, "R9 read setup rewrite in flight");
        check_rdata(16'ha5c3, "R6 R9 captured after setup rewrite");
        xfer(panel_cmd_pkg::ADDR_RSTART, 32'h1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0, 0, 3'd0, 32'h0,
             "R9 new read setup on next cycle");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule